// File: doc/BRIEF.md
# Step-Sequenced Accumulator Processor

This block is a small multicycle processor with a single accumulator. Its control unit runs register-transfer micro-operations one clock step at a time. Each clock edge performs one step, and steps are grouped into four major cycles: fetch, indirect, execute and interrupt. A two-bit cycle code selects the major cycle, and a step counter tracks the position inside it. The programmer-visible and internal registers are the program counter, the instruction register, the memory address register, the memory buffer register and the accumulator.

An instruction word is 16 bits wide. Bit 15 is the indirect flag, bits 14:12 hold the opcode and bits 11:0 hold the address. Three opcodes do work in the execute cycle: 1 adds a memory word to the accumulator, 2 increments a memory word and skips the next instruction when the result is zero, and 3 saves the return address at X and continues at X+1. Every other opcode is a one-step no-operation.

Memory is external. The processor presents its address register as the address and its buffer register as the write data. Read data must be valid combinationally for the presented address, and a write takes effect at the clock edge while the write enable is high. A halt input freezes all stepping, and a set of debug outputs shows every register together with the cycle code and the step number.

Top module: `mcpu_core`

## Requirements
- R1: With `rst_n` low at a clock edge, the processor clears PC, IR, MAR, MBR, the accumulator, the step counter and the interrupt enable, and selects fetch (cycle code 00).
- R2: Fetch (code 00) takes three steps: MAR takes PC; then MBR takes the memory word and PC increments; then IR takes MBR.
- R3: After fetch, the cycle code becomes 01 (indirect) when bit 15 of the fetched word is set, and 10 (execute) otherwise. Indirect takes three steps (MAR takes IR[11:0]; MBR takes memory; IR[11:0] takes MBR[11:0]) and then goes to execute.
- R4: Opcode 1 takes three execute steps: MAR takes the address, MBR takes memory, and the accumulator takes the accumulator plus MBR (modulo 2^16).
- R5: Opcode 2 takes four execute steps: load MAR, read MBR, increment MBR, then write MBR back to memory. In that last step PC also increments when MBR is zero.
- R6: Opcode 3 takes three execute steps: MAR takes X and MBR takes the zero-extended PC; then PC takes X and memory[X] is written with MBR; then PC increments.
- R7: Opcodes 0 and 4 to 7 finish execute in a single step and change no register other than the cycle code and the step.
- R8: When execute ends with `irq` high and the interrupt enable set, the cycle code becomes 11 and the enable clears. Interrupt takes three steps: MBR takes PC; then MAR takes 0 and PC takes 1; then memory[0] is written with MBR. Fetch follows. A pulse on `ien_set` sets the enable, and the clear wins if both happen at the same edge.
- R9: With the interrupt enable clear, `irq` has no effect, and the cycle code never becomes 11.
- R10: While `halt` is high, no register, step or cycle code changes and `mem_we` stays low.
- R11: The step counter returns to step 0 whenever the cycle code changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one micro-operation step per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| halt | input | 1 | Freezes stepping while high |
| irq | input | 1 | Interrupt request level, sampled at the end of execute |
| ien_set | input | 1 | Sets the interrupt enable flag |
| mem_addr | output | 12 | Memory address (the MAR) |
| mem_wdata | output | 16 | Memory write data (the MBR) |
| mem_rdata | input | 16 | Memory read data for `mem_addr`, valid in the same cycle |
| mem_we | output | 1 | Memory write enable, active in write steps |
| dbg_pc | output | 12 | Program counter |
| dbg_ir | output | 16 | Instruction register |
| dbg_mar | output | 12 | Memory address register |
| dbg_mbr | output | 16 | Memory buffer register |
| dbg_r1 | output | 16 | Accumulator |
| dbg_cyc | output | 2 | Major cycle code (00 fetch, 01 indirect, 10 execute, 11 interrupt) |
| dbg_step | output | 2 | Step number inside the major cycle, starting at 0 |
| dbg_ien | output | 1 | Interrupt enable flag |

## Verification
The assertions assume that `halt`, `irq` and `ien_set` change only between clock edges, that `rst_n` is low at the first edge, and that `mem_rdata` reflects the presented address within the same cycle. The bench changes every input on the falling edge. It models memory as a word array that reads combinationally and writes on the rising edge. It raises `irq` both with the enable clear and with it set, and it holds `halt` across steps of a running instruction.

// File: rtl/mcpu_pkg.sv
// Package: shared types for the step-sequenced accumulator processor.
// Holds the major-cycle encoding, the step-counter width and the bundle
// of micro-operation strobes that the sequencer hands to the datapath.
package mcpu_pkg;

    localparam int MAX_STEPS = 4;
    localparam int STEP_W    = $clog2(MAX_STEPS);

    typedef enum logic [1:0] {
        CYC_FETCH = 2'b00,
        CYC_INDIR = 2'b01,
        CYC_EXEC  = 2'b10,
        CYC_INTR  = 2'b11
    } cyc_e;

    // One strobe per register transfer; several may be active in one step.
    typedef struct packed {
        logic mar_pc;    // MAR <- PC
        logic mar_ir;    // MAR <- IR address field
        logic mar_save;  // MAR <- save address
        logic mbr_mem;   // MBR <- memory
        logic mbr_pc;    // MBR <- PC
        logic mbr_inc;   // MBR <- MBR + 1
        logic ir_all;    // IR <- MBR
        logic ir_addr;   // IR address <- MBR address
        logic pc_inc;    // PC <- PC + 1
        logic pc_skip;   // PC <- PC + 1 when MBR is zero
        logic pc_ir;     // PC <- IR address
        logic pc_vec;    // PC <- service routine address
        logic r1_add;    // R1 <- R1 + MBR
        logic mem_wr;    // memory[MAR] <- MBR
    } ctl_t;

endpackage

// File: rtl/mcpu_seq.sv
// Module: mcpu_seq
// Control sequencer. Holds the two-bit major cycle code, the step counter
// and the interrupt enable flag, and decodes (cycle, step, opcode) into
// the micro-operation strobes for the current step.
// Assumes: op is the IR opcode and stays stable through execute; ind_bit is
// bit 15 of MBR, which holds the fetched word in the last fetch step.
module mcpu_seq
    import mcpu_pkg::*;
#(
    parameter int OP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    input  logic              irq,
    input  logic              ien_set,
    input  logic [OP_W-1:0]   op,
    input  logic              ind_bit,
    output ctl_t              ctl,
    output cyc_e              cyc,
    output logic [STEP_W-1:0] step,
    output logic              ien
);

    localparam logic [OP_W-1:0] OP_ADD = OP_W'(1);
    localparam logic [OP_W-1:0] OP_ISZ = OP_W'(2);
    localparam logic [OP_W-1:0] OP_BSA = OP_W'(3);

    cyc_e              cyc_q;
    logic [STEP_W-1:0] step_q;
    logic              ien_q;
    ctl_t              ctl_raw;
    logic              last;
    cyc_e              nxt;

    // Decode the strobes, the end of the cycle and the next cycle code.
    always_comb begin
        ctl_raw = '0;
        last    = 1'b0;
        nxt     = CYC_FETCH;
        case (cyc_q)
            CYC_FETCH: begin
                case (step_q)
                    STEP_W'(0): ctl_raw.mar_pc = 1'b1;
                    STEP_W'(1): begin
                        ctl_raw.mbr_mem = 1'b1;
                        ctl_raw.pc_inc  = 1'b1;
                    end
                    default: begin
                        ctl_raw.ir_all = 1'b1;
                        last           = 1'b1;
                        nxt            = ind_bit ? CYC_INDIR : CYC_EXEC;
                    end
                endcase
            end
            CYC_INDIR: begin
                nxt = CYC_EXEC;
                case (step_q)
                    STEP_W'(0): ctl_raw.mar_ir  = 1'b1;
                    STEP_W'(1): ctl_raw.mbr_mem = 1'b1;
                    default: begin
                        ctl_raw.ir_addr = 1'b1;
                        last            = 1'b1;
                    end
                endcase
            end
            CYC_EXEC: begin
                nxt = (irq && ien_q) ? CYC_INTR : CYC_FETCH;
                if (op == OP_ADD) begin
                    case (step_q)
                        STEP_W'(0): ctl_raw.mar_ir  = 1'b1;
                        STEP_W'(1): ctl_raw.mbr_mem = 1'b1;
                        default: begin
                            ctl_raw.r1_add = 1'b1;
                            last           = 1'b1;
                        end
                    endcase
                end else if (op == OP_ISZ) begin
                    case (step_q)
                        STEP_W'(0): ctl_raw.mar_ir  = 1'b1;
                        STEP_W'(1): ctl_raw.mbr_mem = 1'b1;
                        STEP_W'(2): ctl_raw.mbr_inc = 1'b1;
                        default: begin
                            ctl_raw.mem_wr  = 1'b1;
                            ctl_raw.pc_skip = 1'b1;
                            last            = 1'b1;
                        end
                    endcase
                end else if (op == OP_BSA) begin
                    case (step_q)
                        STEP_W'(0): begin
                            ctl_raw.mar_ir = 1'b1;
                            ctl_raw.mbr_pc = 1'b1;
                        end
                        STEP_W'(1): begin
                            ctl_raw.pc_ir  = 1'b1;
                            ctl_raw.mem_wr = 1'b1;
                        end
                        default: begin
                            ctl_raw.pc_inc = 1'b1;
                            last           = 1'b1;
                        end
                    endcase
                end else begin
                    last = 1'b1;
                end
            end
            default: begin
                case (step_q)
                    STEP_W'(0): ctl_raw.mbr_pc = 1'b1;
                    STEP_W'(1): begin
                        ctl_raw.mar_save = 1'b1;
                        ctl_raw.pc_vec   = 1'b1;
                    end
                    default: begin
                        ctl_raw.mem_wr = 1'b1;
                        last           = 1'b1;
                    end
                endcase
            end
        endcase
    end

    // Halt suppresses every transfer of the current step.
    assign ctl = halt ? '0 : ctl_raw;

    // Advance the step counter, or move to the next major cycle at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q  <= CYC_FETCH;
            step_q <= '0;
        end else if (!halt) begin
            if (last) begin
                cyc_q  <= nxt;
                step_q <= '0;
            end else begin
                step_q <= step_q + 1'b1;
            end
        end
    end

    // Interrupt enable: cleared on entry to interrupt, set by request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ien_q <= 1'b0;
        else if (!halt && last && nxt == CYC_INTR)
            ien_q <= 1'b0;
        else if (ien_set)
            ien_q <= 1'b1;
    end

    assign cyc  = cyc_q;
    assign step = step_q;
    assign ien  = ien_q;

    // R11
    step_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q != $past(cyc_q)) |-> (step_q == '0));

    // R2
    fetch_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == CYC_FETCH) |-> (step_q <= STEP_W'(2)));

    // R8
    intr_ien_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == CYC_INTR && step_q == '0) |-> !ien_q);

    // R9
    intr_needs_ien_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == CYC_INTR && $past(cyc_q) != CYC_INTR) |-> $past(ien_q));

endmodule

// File: rtl/mcpu_dp.sv
// Module: mcpu_dp
// Register datapath: PC, IR, MAR, MBR and the accumulator R1, each loaded
// by the strobes of the sequencer. Memory read data is taken as valid in
// the same cycle for the address held in MAR.
// Assumes: the sequencer never raises two strobes for one register at once.
module mcpu_dp
    import mcpu_pkg::*;
#(
    parameter int              WORD_W    = 16,
    parameter int              ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] SAVE_ADDR = '0,
    parameter logic [ADDR_W-1:0] VEC_ADDR  = ADDR_W'(1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_t              ctl,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] pc,
    output logic [WORD_W-1:0] ir,
    output logic [ADDR_W-1:0] mar,
    output logic [WORD_W-1:0] mbr,
    output logic [WORD_W-1:0] r1
);

    localparam int PAD_W = WORD_W - ADDR_W;

    logic [ADDR_W-1:0] pc_q, mar_q;
    logic [WORD_W-1:0] ir_q, mbr_q, r1_q;
    logic              mbr_zero;

    assign mbr_zero = (mbr_q == '0);

    // Address register: from PC, from the IR address, or the save slot.
    always_ff @(posedge clk) begin
        if (!rst_n)             mar_q <= '0;
        else if (ctl.mar_pc)    mar_q <= pc_q;
        else if (ctl.mar_ir)    mar_q <= ir_q[ADDR_W-1:0];
        else if (ctl.mar_save)  mar_q <= SAVE_ADDR;
    end

    // Buffer register: memory read, saved PC, or increment.
    always_ff @(posedge clk) begin
        if (!rst_n)            mbr_q <= '0;
        else if (ctl.mbr_mem)  mbr_q <= mem_rdata;
        else if (ctl.mbr_pc)   mbr_q <= {{PAD_W{1'b0}}, pc_q};
        else if (ctl.mbr_inc)  mbr_q <= mbr_q + 1'b1;
    end

    // Instruction register: full load, or address field replacement.
    always_ff @(posedge clk) begin
        if (!rst_n)            ir_q <= '0;
        else if (ctl.ir_all)   ir_q <= mbr_q;
        else if (ctl.ir_addr)  ir_q[ADDR_W-1:0] <= mbr_q[ADDR_W-1:0];
    end

    // Program counter: increment, conditional skip, jump, or vector.
    always_ff @(posedge clk) begin
        if (!rst_n)                        pc_q <= '0;
        else if (ctl.pc_vec)               pc_q <= VEC_ADDR;
        else if (ctl.pc_ir)                pc_q <= ir_q[ADDR_W-1:0];
        else if (ctl.pc_inc)               pc_q <= pc_q + 1'b1;
        else if (ctl.pc_skip && mbr_zero)  pc_q <= pc_q + 1'b1;
    end

    // Accumulator: add the buffer register.
    always_ff @(posedge clk) begin
        if (!rst_n)           r1_q <= '0;
        else if (ctl.r1_add)  r1_q <= r1_q + mbr_q;
    end

    assign pc  = pc_q;
    assign ir  = ir_q;
    assign mar = mar_q;
    assign mbr = mbr_q;
    assign r1  = r1_q;

    // R5
    skip_only_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl.pc_skip) && $past(mbr_q) != '0) |-> (pc_q == $past(pc_q)));

endmodule

// File: rtl/mcpu_core.sv
// Module: mcpu_core
// Top of the step-sequenced accumulator processor. It joins the sequencer
// and the datapath, drives the memory port from MAR and MBR, and exposes
// every register for a halt or debug view.
// Assumes: memory returns mem_rdata for mem_addr in the same cycle and
// writes on the rising edge while mem_we is high.
module mcpu_core
    import mcpu_pkg::*;
#(
    parameter int              WORD_W    = 16,
    parameter int              ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] SAVE_ADDR = '0,
    parameter logic [ADDR_W-1:0] VEC_ADDR  = ADDR_W'(1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    input  logic              irq,
    input  logic              ien_set,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] dbg_pc,
    output logic [WORD_W-1:0] dbg_ir,
    output logic [ADDR_W-1:0] dbg_mar,
    output logic [WORD_W-1:0] dbg_mbr,
    output logic [WORD_W-1:0] dbg_r1,
    output logic [1:0]        dbg_cyc,
    output logic [STEP_W-1:0] dbg_step,
    output logic              dbg_ien
);

    localparam int OP_W = WORD_W - 1 - ADDR_W;

    ctl_t              ctl;
    cyc_e              cyc;
    logic [STEP_W-1:0] step;
    logic              ien;
    logic [ADDR_W-1:0] pc, mar;
    logic [WORD_W-1:0] ir, mbr, r1;

    mcpu_seq #(.OP_W(OP_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .halt    (halt),
        .irq     (irq),
        .ien_set (ien_set),
        .op      (ir[WORD_W-2:ADDR_W]),
        .ind_bit (mbr[WORD_W-1]),
        .ctl     (ctl),
        .cyc     (cyc),
        .step    (step),
        .ien     (ien)
    );

    mcpu_dp #(
        .WORD_W    (WORD_W),
        .ADDR_W    (ADDR_W),
        .SAVE_ADDR (SAVE_ADDR),
        .VEC_ADDR  (VEC_ADDR)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .pc        (pc),
        .ir        (ir),
        .mar       (mar),
        .mbr       (mbr),
        .r1        (r1)
    );

    assign mem_addr  = mar;
    assign mem_wdata = mbr;
    assign mem_we    = ctl.mem_wr;

    assign dbg_pc   = pc;
    assign dbg_ir   = ir;
    assign dbg_mar  = mar;
    assign dbg_mbr  = mbr;
    assign dbg_r1   = r1;
    assign dbg_cyc  = cyc;
    assign dbg_step = step;
    assign dbg_ien  = ien;

    // R10
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(halt) |-> (pc == $past(pc) && r1 == $past(r1) &&
                         cyc == $past(cyc) && step == $past(step)));

    // R10
    halt_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !mem_we);

endmodule

// File: tb/tb_mcpu_core.sv
// Bench for mcpu_core: a behavioural step model runs next to the design and
// every debug output and memory strobe is compared on each clock.
module tb_mcpu_core;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, halt, irq, ien_set;
    logic [11:0] mem_addr, dbg_pc, dbg_mar;
    logic [15:0] mem_wdata, mem_rdata, dbg_ir, dbg_mbr, dbg_r1;
    logic        mem_we, dbg_ien;
    logic [1:0]  dbg_cyc, dbg_step;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    logic [15:0] mem [4096];
    logic [15:0] mm  [4096];

    // Reference model state.
    logic [11:0] m_pc, m_mar;
    logic [15:0] m_ir, m_mbr, m_r1;
    int          m_cyc, m_step;
    bit          m_ien;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcpu_core dut (
        .clk(clk), .rst_n(rst_n), .halt(halt), .irq(irq), .ien_set(ien_set),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_we(mem_we), .dbg_pc(dbg_pc), .dbg_ir(dbg_ir), .dbg_mar(dbg_mar),
        .dbg_mbr(dbg_mbr), .dbg_r1(dbg_r1), .dbg_cyc(dbg_cyc),
        .dbg_step(dbg_step), .dbg_ien(dbg_ien)
    );

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h @%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic string ctx_tag();
        int op;
        op = int'(m_ir[14:12]);
        if (halt) return "R10";
        case (m_cyc)
            0: return "R2";
            1: return "R3";
            2: return (op == 1) ? "R4" : (op == 2) ? "R5" : (op == 3) ? "R6" : "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic bit exp_we();
        int op;
        op = int'(m_ir[14:12]);
        if (halt) return 1'b0;
        return (m_cyc == 2 && op == 2 && m_step == 3) ||
               (m_cyc == 2 && op == 3 && m_step == 1) ||
               (m_cyc == 3 && m_step == 2);
    endfunction

    // One step of the reference model, applied on each rising edge.
    task automatic model_tick();
        bit fin;
        int nxt;
        int op;
        if (!rst_n) begin
            m_pc = 0; m_mar = 0; m_ir = 0; m_mbr = 0; m_r1 = 0;
            m_cyc = 0; m_step = 0; m_ien = 0;
            return;
        end
        fin = 0; nxt = 0;
        op  = int'(m_ir[14:12]);
        if (!halt) begin
            if (m_cyc == 0) begin
                if (m_step == 0) m_mar = m_pc;
                else if (m_step == 1) begin m_mbr = mm[m_mar]; m_pc = m_pc + 1; end
                else begin m_ir = m_mbr; fin = 1; nxt = m_mbr[15] ? 1 : 2; end
            end else if (m_cyc == 1) begin
                if (m_step == 0) m_mar = m_ir[11:0];
                else if (m_step == 1) m_mbr = mm[m_mar];
                else begin m_ir[11:0] = m_mbr[11:0]; fin = 1; nxt = 2; end
            end else if (m_cyc == 2) begin
                nxt = (irq && m_ien) ? 3 : 0;
                if (op == 1) begin
                    if (m_step == 0) m_mar = m_ir[11:0];
                    else if (m_step == 1) m_mbr = mm[m_mar];
                    else begin m_r1 = m_r1 + m_mbr; fin = 1; end
                end else if (op == 2) begin
                    if (m_step == 0) m_mar = m_ir[11:0];
                    else if (m_step == 1) m_mbr = mm[m_mar];
                    else if (m_step == 2) m_mbr = m_mbr + 1;
                    else begin
                        mm[m_mar] = m_mbr;
                        if (m_mbr == 0) m_pc = m_pc + 1;
                        fin = 1;
                    end
                end else if (op == 3) begin
                    if (m_step == 0) begin m_mar = m_ir[11:0]; m_mbr = {4'b0, m_pc}; end
                    else if (m_step == 1) begin m_pc = m_ir[11:0]; mm[m_mar] = m_mbr; end
                    else begin m_pc = m_pc + 1; fin = 1; end
                end else begin
                    fin = 1;
                end
            end else begin
                if (m_step == 0) m_mbr = {4'b0, m_pc};
                else if (m_step == 1) begin m_mar = 0; m_pc = 1; end
                else begin mm[m_mar] = m_mbr; fin = 1; nxt = 0; end
            end
            if (fin) begin m_cyc = nxt; m_step = 0; end
            else m_step = m_step + 1;
        end
        if (!halt && fin && nxt == 3) m_ien = 0;
        else if (ien_set) m_ien = 1;
    endtask

    always @(posedge clk) model_tick();

    // Per-clock comparison, away from the active edge.
    always @(negedge clk) begin
        #1;
        if (!done && rst_n === 1'b1) begin
            string t;
            t = ctx_tag();
            chk(t, "pc", int'(dbg_pc), int'(m_pc));
            chk(t, "ir", int'(dbg_ir), int'(m_ir));
            chk(t, "mar", int'(dbg_mar), int'(m_mar));
            chk(t, "mbr", int'(dbg_mbr), int'(m_mbr));
            chk(t, "r1", int'(dbg_r1), int'(m_r1));
            chk("R11", "cycle code", int'(dbg_cyc), m_cyc);
            chk("R11", "step", int'(dbg_step), m_step);
            chk("R8", "enable flag", int'(dbg_ien), int'(m_ien));
            chk(t, "mem_we", int'(mem_we), int'(exp_we()));
            if (exp_we()) begin
                chk(t, "mem_addr", int'(mem_addr), int'(m_mar));
                chk(t, "mem_wdata", int'(mem_wdata), int'(m_mbr));
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [11:0] h_pc;
        logic [15:0] h_r1;
        logic [1:0]  h_cyc, h_step;
        bit          seen;
        rst_n = 1'b0; halt = 1'b0; irq = 1'b0; ien_set = 1'b0;
        for (int i = 0; i < 4096; i++) begin mem[i] = 16'h0; mm[i] = 16'h0; end
        // Program image: opcode 1 add, 2 increment-skip, 3 save-and-branch.
        mem[12'h000] = 16'h3010;               // save-branch to 0x010
        mem[12'h001] = 16'h1100;               // interrupt routine: add
        mem[12'h002] = 16'h3020;               // save-branch to 0x020
        mem[12'h011] = 16'h1100;               // add [0x100]
        mem[12'h012] = 16'h9101;               // add indirect via 0x101
        mem[12'h013] = 16'h2103;               // inc-skip [0x103]: no skip
        mem[12'h014] = 16'h2103;               // inc-skip [0x103]: skip
        mem[12'h015] = 16'h1100;               // skipped
        mem[12'h016] = 16'h7000;               // undefined opcode 7
        mem[12'h017] = 16'h0000;               // undefined opcode 0
        mem[12'h018] = 16'hA104;               // inc-skip indirect via 0x104
        mem[12'h019] = 16'h1100;               // add [0x100]
        mem[12'h100] = 16'h0005;
        mem[12'h101] = 16'h0102;
        mem[12'h102] = 16'h0007;
        mem[12'h103] = 16'hFFFE;
        mem[12'h104] = 16'h0103;
        for (int i = 0; i < 4096; i++) mm[i] = mem[i];

        repeat (3) @(negedge clk);
        #2;
        // R1: reset state
        chk("R1", "pc", int'(dbg_pc), 0);
        chk("R1", "cycle code", int'(dbg_cyc), 0);
        chk("R1", "step", int'(dbg_step), 0);
        chk("R1", "enable flag", int'(dbg_ien), 0);
        chk("R1", "r1", int'(dbg_r1), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: request held with the enable clear must never enter interrupt.
        irq = 1'b1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk); #2;
            chk("R9", "cycle code not 11", int'(dbg_cyc == 2'b11), 0);
        end
        irq = 1'b0;

        // R10: freeze in the middle of a running instruction.
        @(negedge clk); #2;
        halt = 1'b1;
        h_pc = dbg_pc; h_r1 = dbg_r1; h_cyc = dbg_cyc; h_step = dbg_step;
        repeat (6) @(negedge clk);
        #2;
        chk("R10", "pc held", int'(dbg_pc), int'(h_pc));
        chk("R10", "r1 held", int'(dbg_r1), int'(h_r1));
        chk("R10", "cycle held", int'(dbg_cyc), int'(h_cyc));
        chk("R10", "step held", int'(dbg_step), int'(h_step));
        chk("R10", "no write", int'(mem_we), 0);
        @(negedge clk);
        halt = 1'b0;

        repeat (80) @(negedge clk);

        // R8: enable, then request until the interrupt cycle is entered.
        ien_set = 1'b1;
        @(negedge clk);
        ien_set = 1'b0;
        irq = 1'b1;
        seen = 0;
        for (int i = 0; i < 100 && !seen; i++) begin
            @(negedge clk); #2;
            if (dbg_cyc == 2'b11) seen = 1;
        end
        chk("R8", "interrupt entered", int'(seen), 1);
        chk("R8", "enable cleared", int'(dbg_ien), 0);
        irq = 1'b0;
        repeat (40) @(negedge clk);
        #2;

        chk("R6", "return address at 0x010", int'(mem[12'h010]), 1);
        chk("R6", "return address at 0x020", int'(mem[12'h020]), 3);
        chk("R5", "counter word 0x103", int'(mem[12'h103]), 1);
        chk("R8", "saved pc at 0", int'(mem[12'h000]), int'(mm[12'h000]));
        chk("R4", "accumulator", int'(dbg_r1), int'(m_r1));
        chk("R3", "indirect operand sum seen", int'(m_r1 >= 16'd17), 1);
        chk("R7", "pc after run", int'(dbg_pc), int'(m_pc));

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule